// File: doc/BRIEF.md
# Spiking Band Power Extractor

This block turns a stream of rectified multichannel neural samples into one averaged power figure per channel per bin. Up to three acquisition lanes each deliver up to 31 channel samples of 16 bits every time step (0.5 ms at 2 kSps). The block gathers a step's samples into one small FIFO per lane. It can also form a common average over a separately chosen set of reference channels, subtract it from every sample and keep a running sum per channel. After a configurable number of steps it scales every sum by a reciprocal to give the bin's feature.

Software supplies the two reciprocals, one for the bin length and one for the reference count, as unsigned Q0.16 values. It also sets a truncation amount that clears the low bits of every sample and every intermediate result. That way only the upper bits toggle when reduced precision is enough. Results sit in a register array that is rewritten once per bin. A one-cycle pulse marks the moment the whole array is current.

Top module: `sbp_extractor`

## Requirements
- R1: While reset is high and right after it, `bin_done` is 0, `car_out` is 0, every feature is 0, and `lane_ready` is high for each lane that has an enabled channel.
- R2: Channel c = 31*L + k is lane L's position k, enabled by `chan_en[c]`. Each step a lane delivers its enabled channels' samples in ascending k. A disabled channel takes no sample and keeps its previous feature value.
- R3: With truncation amount s, the low s bits are cleared in each accepted sample, the common average, each referenced value and each feature.
- R4: With referencing on, the step's average is floor(S*ref_recip/65536), limited to 65535 and then truncated. S is the sum of the truncated samples of the channels that are both enabled and set in `ref_sel`. The average appears on `car_out`.
- R5: With referencing off, `car_out` becomes 0 at the next step and samples are accumulated unmodified.
- R6: The referenced value is the truncated sample minus the step's average. It is clamped at 0 when negative.
- R7: After `bin_len` steps (0 counts as 1), each enabled channel's feature becomes floor(A*bin_recip/65536), limited to 65535 and truncated, where A is its sum. All sums then clear, and `bin_done` pulses for one cycle once all features are written.
- R8: A channel's 24-bit sum saturates at 16777215 instead of wrapping.
- R9: `lane_ready` of a lane drops after its last enabled sample of the step and stays low until the next step. Data offered while it is low is ignored.
- R10: Reference samples that arrive on all three lanes in the same cycle all enter that step's average.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lane_valid | input | 3 | Sample offered, one bit per lane |
| lane_data | input | 48 | Samples, lane L in bits 16L+15..16L |
| lane_ready | output | 3 | Lane may deliver a sample this cycle |
| chan_en | input | 93 | Channel sampling enables |
| ref_sel | input | 93 | Channels feeding the common average |
| ref_en | input | 1 | Subtract the common average |
| shift_amt | input | 4 | Number of low bits cleared |
| bin_len | input | 16 | Steps per bin |
| bin_recip | input | 16 | Reciprocal of bin length, Q0.16 |
| ref_recip | input | 16 | Reciprocal of reference count, Q0.16 |
| car_out | output | 16 | Common average of the latest step |
| feat_out | output | 1488 | Features, channel c in bits 16c+15..16c |
| bin_done | output | 1 | One-cycle pulse when the features are updated |

## Verification
Two events can land in the same clock edge: accepted samples on all three lanes and the reference-sum update that takes all of them. The bench drives every lane from the first position with reference channels 0, 31 and 62 selected, so all three arrive together. It then compares `car_out` with a sum formed from all of them, so a lost lane shows up as a wrong average. A second collision pits a lane that has finished its quota against further valid data. The bench keeps that lane's data valid with all-ones while the other lanes are still delivering. Any sample taken in would shift the lane's FIFO and corrupt the next bin's features.

// File: rtl/sbp_pkg.sv
package sbp_pkg;
  // Phases of one time step; scaling runs only at the end of a bin.
  typedef enum logic [1:0] {
    ST_COLLECT = 2'd0,
    ST_CAR     = 2'd1,
    ST_APPLY   = 2'd2,
    ST_SCALE   = 2'd3
  } sbp_state_e;
endpackage

// File: rtl/sbp_lane_fifo.sv
module sbp_lane_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == PW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
    end
  end

  assign dout = mem[rd_ptr];
endmodule

// File: rtl/sbp_lane_scan.sv
module sbp_lane_scan #(
  parameter int CPL = 31,
  parameter int IW  = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           restart,
  input  logic [CPL-1:0] en,
  input  logic           collecting,
  input  logic           valid,
  output logic           ready,
  output logic           accept,
  output logic [IW-1:0]  idx,
  output logic           done
);
  logic [IW-1:0] k;
  logic [IW-1:0] nxt;

  // Lowest enabled position at or above the scan point.
  always_comb begin
    nxt = IW'(CPL);
    for (int i = CPL-1; i >= 0; i--) begin
      if (en[i] && (i >= int'(k))) nxt = IW'(i);
    end
  end

  assign done   = (nxt == IW'(CPL));
  assign ready  = collecting && !done;
  assign accept = ready && valid;
  assign idx    = nxt;

  always_ff @(posedge clk) begin
    if (rst || restart) k <= '0;
    else if (accept)    k <= nxt + 1'b1;
  end
endmodule

// File: rtl/sbp_accum_bank.sv
module sbp_accum_bank #(
  parameter int NCH = 93,
  parameter int SW  = 16,
  parameter int AW  = 24,
  parameter int RW  = 16,
  parameter int SHW = 4,
  parameter int CW  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_we,
  input  logic [CW-1:0]     acc_idx,
  input  logic [SW-1:0]     acc_add,
  input  logic              scl_we,
  input  logic [CW-1:0]     scl_idx,
  input  logic              scl_en,
  input  logic [RW-1:0]     recip,
  input  logic [SHW-1:0]    shift_amt,
  output logic [NCH*SW-1:0] feat_flat
);
  logic [AW-1:0] acc  [NCH];
  logic [SW-1:0] feat [NCH];

  logic [AW:0]      sum;
  logic [AW-1:0]    acc_next;
  logic [AW+RW-1:0] scl_q;
  logic [SW-1:0]    scl_val;

  assign sum      = {1'b0, acc[acc_idx]} + {{(AW-SW+1){1'b0}}, acc_add};
  assign acc_next = sum[AW] ? {AW{1'b1}} : sum[AW-1:0];

  assign scl_q = (acc[scl_idx] * recip) >> RW;

  always_comb begin
    scl_val = (|scl_q[AW+RW-1:SW]) ? {SW{1'b1}} : scl_q[SW-1:0];
    scl_val = scl_val & ({SW{1'b1}} << shift_amt);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NCH; i++) begin
        acc[i]  <= '0;
        feat[i] <= '0;
      end
    end else begin
      if (acc_we) acc[acc_idx] <= acc_next;
      if (scl_we) begin
        acc[scl_idx] <= '0;
        if (scl_en) feat[scl_idx] <= scl_val;
      end
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_flat
    assign feat_flat[c*SW +: SW] = feat[c];
  end
endmodule

// File: rtl/sbp_extractor.sv
module sbp_extractor
  import sbp_pkg::*;
#(
  parameter int LANES      = 3,
  parameter int CPL        = 31,
  parameter int SW         = 16,
  parameter int AW         = 24,
  parameter int RW         = 16,
  parameter int SHW        = 4,
  parameter int BLW        = 16,
  parameter int FIFO_DEPTH = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [LANES-1:0]        lane_valid,
  input  logic [LANES*SW-1:0]     lane_data,
  output logic [LANES-1:0]        lane_ready,
  input  logic [LANES*CPL-1:0]    chan_en,
  input  logic [LANES*CPL-1:0]    ref_sel,
  input  logic                    ref_en,
  input  logic [SHW-1:0]          shift_amt,
  input  logic [BLW-1:0]          bin_len,
  input  logic [RW-1:0]           bin_recip,
  input  logic [RW-1:0]           ref_recip,
  output logic [SW-1:0]           car_out,
  output logic [LANES*CPL*SW-1:0] feat_out,
  output logic                    bin_done
);
  localparam int NCH = LANES * CPL;
  localparam int CW  = $clog2(NCH);
  localparam int IW  = $clog2(CPL + 1);
  localparam int LW  = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int RSW = SW + $clog2(NCH + 1);

  function automatic logic [SW-1:0] keep_upper(input logic [SW-1:0] v,
                                               input logic [SHW-1:0] sh);
    return v & ({SW{1'b1}} << sh);
  endfunction

  sbp_state_e      state;
  logic [LW-1:0]   lane_i;
  logic [IW-1:0]   k_i;
  logic [BLW-1:0]  step_cnt;
  logic [RSW-1:0]  refsum;
  logic [RSW-1:0]  ref_step;
  logic [SW-1:0]   car_q;
  logic            bin_done_q;

  logic            collecting;
  logic            restart;
  logic            all_done;
  logic [LANES-1:0] acc_l, done_l, pop_l;
  logic [IW-1:0]   idx_l    [LANES];
  logic [SW-1:0]   head_l   [LANES];
  logic [SW-1:0]   refadd_l [LANES];

  logic [CW-1:0]   c_i;
  logic            en_cur;
  logic            last_ch;
  logic            pop_now;
  logic [SW-1:0]   head;
  logic [SW:0]     diff;
  logic [SW-1:0]   ref_val;
  logic [BLW:0]    bl_eff;
  logic            bin_end;
  logic [RSW+RW-1:0] car_raw;
  logic [SW-1:0]   car_next;
  logic            scale_busy;

  assign collecting = (state == ST_COLLECT);
  assign scale_busy = (state == ST_SCALE);

  // ---------------- per-lane intake ----------------
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [SW-1:0]  smp;
    logic [CPL-1:0] rsel;

    assign smp  = keep_upper(lane_data[l*SW +: SW], shift_amt);
    assign rsel = ref_sel[l*CPL +: CPL];

    sbp_lane_scan #(.CPL(CPL), .IW(IW)) u_scan (
      .clk        (clk),
      .rst        (rst),
      .restart    (restart),
      .en         (chan_en[l*CPL +: CPL]),
      .collecting (collecting),
      .valid      (lane_valid[l]),
      .ready      (lane_ready[l]),
      .accept     (acc_l[l]),
      .idx        (idx_l[l]),
      .done       (done_l[l])
    );

    sbp_lane_fifo #(.W(SW), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk  (clk),
      .rst  (rst),
      .push (acc_l[l]),
      .din  (smp),
      .pop  (pop_l[l]),
      .dout (head_l[l])
    );

    assign refadd_l[l] = (acc_l[l] && ref_en && rsel[idx_l[l]]) ? smp : '0;
    assign pop_l[l]    = pop_now && (lane_i == LW'(l));
  end

  always_comb begin
    ref_step = '0;
    for (int l = 0; l < LANES; l++) ref_step = ref_step + RSW'(refadd_l[l]);
  end

  assign all_done = &done_l;

  // ---------------- common average ----------------
  assign car_raw = (refsum * ref_recip) >> RW;
  always_comb begin
    car_next = (|car_raw[RSW+RW-1:SW]) ? {SW{1'b1}} : car_raw[SW-1:0];
    car_next = keep_upper(car_next, shift_amt);
  end

  // ---------------- channel walk ----------------
  assign c_i     = CW'(int'(lane_i) * CPL + int'(k_i));
  assign en_cur  = chan_en[c_i];
  assign last_ch = (lane_i == LW'(LANES-1)) && (k_i == IW'(CPL-1));
  assign pop_now = (state == ST_APPLY) && en_cur;
  assign head    = head_l[lane_i];
  assign diff    = {1'b0, head} - {1'b0, car_q};
  assign ref_val = diff[SW] ? '0 : keep_upper(diff[SW-1:0], shift_amt);

  assign bl_eff  = (bin_len == '0) ? (BLW+1)'(1) : {1'b0, bin_len};
  assign bin_end = (({1'b0, step_cnt} + 1'b1) >= bl_eff);
  assign restart = last_ch && (((state == ST_APPLY) && !bin_end) || (state == ST_SCALE));

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_COLLECT;
      lane_i     <= '0;
      k_i        <= '0;
      step_cnt   <= '0;
      refsum     <= '0;
      car_q      <= '0;
      bin_done_q <= 1'b0;
    end else begin
      bin_done_q <= 1'b0;
      case (state)
        ST_COLLECT: begin
          refsum <= refsum + ref_step;
          if (all_done) state <= ST_CAR;
        end
        ST_CAR: begin
          car_q  <= ref_en ? car_next : '0;
          refsum <= '0;
          lane_i <= '0;
          k_i    <= '0;
          state  <= ST_APPLY;
        end
        ST_APPLY, ST_SCALE: begin
          if (last_ch) begin
            lane_i <= '0;
            k_i    <= '0;
          end else if (k_i == IW'(CPL-1)) begin
            k_i    <= '0;
            lane_i <= lane_i + 1'b1;
          end else begin
            k_i <= k_i + 1'b1;
          end
          if (last_ch) begin
            if (state == ST_SCALE) begin
              bin_done_q <= 1'b1;
              state      <= ST_COLLECT;
            end else if (bin_end) begin
              step_cnt <= '0;
              state    <= ST_SCALE;
            end else begin
              step_cnt <= step_cnt + 1'b1;
              state    <= ST_COLLECT;
            end
          end
        end
        default: state <= ST_COLLECT;
      endcase
    end
  end

  // ---------------- accumulators and results ----------------
  sbp_accum_bank #(
    .NCH(NCH), .SW(SW), .AW(AW), .RW(RW), .SHW(SHW), .CW(CW)
  ) u_bank (
    .clk       (clk),
    .rst       (rst),
    .acc_we    (pop_now),
    .acc_idx   (c_i),
    .acc_add   (ref_val),
    .scl_we    (scale_busy),
    .scl_idx   (c_i),
    .scl_en    (en_cur),
    .recip     (bin_recip),
    .shift_amt (shift_amt),
    .feat_flat (feat_out)
  );

  assign car_out  = car_q;
  assign bin_done = bin_done_q;
endmodule

// File: rtl/sbp_extractor_chk.sv
module sbp_extractor_chk #(
  parameter int SW  = 16,
  parameter int SHW = 4,
  parameter int NCH = 93
) (
  input logic              clk,
  input logic              rst,
  input logic              ref_en,
  input logic [SHW-1:0]    shift_amt,
  input logic [SW-1:0]     car_out,
  input logic [NCH*SW-1:0] feat_out,
  input logic              bin_done,
  input logic              scale_busy
);
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    bin_done |=> !bin_done);

  p_scale_ends_done_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(scale_busy) |-> bin_done);

  p_feat_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !scale_busy |=> $stable(feat_out));

  p_car_masked_r3: assert property (@(posedge clk) disable iff (rst)
    !$stable(car_out) |-> ((car_out & ~({SW{1'b1}} << shift_amt)) == '0));

  p_car_zero_r5: assert property (@(posedge clk) disable iff (rst)
    ($past(!ref_en) && !$stable(car_out)) |-> (car_out == '0));
endmodule

bind sbp_extractor sbp_extractor_chk #(.SW(SW), .SHW(SHW), .NCH(NCH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ref_en     (ref_en),
  .shift_amt  (shift_amt),
  .car_out    (car_out),
  .feat_out   (feat_out),
  .bin_done   (bin_done),
  .scale_busy (scale_busy)
);

// File: tb/sbp_extractor_tb.sv
module sbp_extractor_tb;
  localparam int LANES = 3;
  localparam int CPL   = 31;
  localparam int NCH   = LANES * CPL;
  localparam int SW    = 16;
  localparam longint SATV = 16777215;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic                 rst;
  logic [LANES-1:0]     lane_valid;
  logic [LANES*SW-1:0]  lane_data;
  logic [LANES-1:0]     lane_ready;
  logic [NCH-1:0]       chan_en, ref_sel;
  logic                 ref_en;
  logic [3:0]           shift_amt;
  logic [15:0]          bin_len, bin_recip, ref_recip;
  logic [15:0]          car_out;
  logic [NCH*SW-1:0]    feat_out;
  logic                 bin_done;

  sbp_extractor u_dut (
    .clk(clk), .rst(rst), .lane_valid(lane_valid), .lane_data(lane_data),
    .lane_ready(lane_ready), .chan_en(chan_en), .ref_sel(ref_sel),
    .ref_en(ref_en), .shift_amt(shift_amt), .bin_len(bin_len),
    .bin_recip(bin_recip), .ref_recip(ref_recip), .car_out(car_out),
    .feat_out(feat_out), .bin_done(bin_done)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  string tag = "R7";

  logic [NCH*SW-1:0] expq [$];
  int     samp [NCH];
  longint macc [NCH];
  int     mres [NCH];
  int     mstep = 0;

  function automatic int tr(input int v);
    return v & ~((1 << int'(shift_amt)) - 1);
  endfunction

  task automatic chk(input string t, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", t, act, exp);
    end
  endtask

  // Scoreboard monitor: one expected feature array per bin.
  always @(negedge clk) begin
    if (!rst && bin_done) begin
      checks++;
      if (expq.size() == 0) begin
        errors++;
        $display("FAIL %s unexpected bin_done act=1 exp=0", tag);
      end else begin
        logic [NCH*SW-1:0] e;
        bit bad;
        e = expq.pop_front();
        bad = 0;
        for (int c = 0; c < NCH; c++) begin
          if (feat_out[c*SW +: SW] !== e[c*SW +: SW]) begin
            if (!bad) $display("FAIL %s ch%0d act=%0d exp=%0d", tag, c,
                               feat_out[c*SW +: SW], e[c*SW +: SW]);
            bad = 1;
          end
        end
        if (bad) errors++;
      end
    end
  end

  task automatic drive_lane(input int l, input bit garbage);
    for (int k = 0; k < CPL; k++) begin
      if (chan_en[l*CPL + k]) begin
        @(negedge clk);
        lane_valid[l] = 1'b0;
        while (!lane_ready[l]) @(negedge clk);
        lane_valid[l] = 1'b1;
        lane_data[l*SW +: SW] = SW'(samp[l*CPL + k]);
        @(posedge clk);
      end
    end
    @(negedge clk);
    lane_valid[l] = 1'b0;
    if (garbage) begin
      chk("R9 ready after quota", lane_ready[l], 0);
      for (int g = 0; g < 4; g++) begin
        lane_valid[l] = 1'b1;
        lane_data[l*SW +: SW] = 16'hFFFF;
        @(negedge clk);
      end
      lane_valid[l] = 1'b0;
    end
  endtask

  // Model one step, push the expected array at a bin end, then drive it.
  task automatic do_step(input bit garbage, input bit check_car, input string t);
    longint sum, q;
    int car, bl;
    sum = 0;
    for (int c = 0; c < NCH; c++)
      if (chan_en[c] && ref_sel[c]) sum += tr(samp[c]);
    car = 0;
    if (ref_en) begin
      q = (sum * ref_recip) >> 16;
      if (q > 65535) q = 65535;
      car = tr(int'(q));
    end
    for (int c = 0; c < NCH; c++) begin
      if (chan_en[c]) begin
        int v;
        v = tr(samp[c]) - car;
        if (v < 0) v = 0;
        v = tr(v);
        macc[c] = macc[c] + v;
        if (macc[c] > SATV) macc[c] = SATV;
      end
    end
    mstep++;
    bl = (bin_len == 0) ? 1 : int'(bin_len);
    if (mstep >= bl) begin
      logic [NCH*SW-1:0] e;
      for (int c = 0; c < NCH; c++) begin
        if (chan_en[c]) begin
          q = (macc[c] * bin_recip) >> 16;
          if (q > 65535) q = 65535;
          mres[c] = tr(int'(q));
        end
        macc[c] = 0;
        e[c*SW +: SW] = SW'(mres[c]);
      end
      mstep = 0;
      expq.push_back(e);
    end
    fork
      drive_lane(0, 1'b0);
      drive_lane(1, 1'b0);
      drive_lane(2, garbage);
    join
    if (check_car) begin
      repeat (4) @(negedge clk);
      chk(t, car_out, car);
    end
  endtask

  task automatic drain();
    while (expq.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin macc[c] = 0; mres[c] = 0; samp[c] = 0; end
    rst = 1'b1;
    lane_valid = '0;
    lane_data = '0;
    chan_en = '1;
    ref_sel = '0;
    ref_en = 1'b0;
    shift_amt = 4'd0;
    bin_len = 16'd4;
    bin_recip = 16'd16384;
    ref_recip = 16'd0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1 bin_done", bin_done, 0);
    chk("R1 car_out", car_out, 0);
    chk("R1 feat_out", (feat_out == '0) ? 1 : 0, 1);
    chk("R1 lane_ready", lane_ready, 3'b111);

    // Plain averaging, every channel on, no referencing: R2, R5, R7.
    tag = "R2 R7";
    for (int s = 0; s < 8; s++) begin
      for (int c = 0; c < NCH; c++) samp[c] = (c * 37 + s * 101) % 4000 + c;
      do_step(1'b0, (s == 1), "R5 car with referencing off");
    end
    drain();

    // Referencing with truncation; channels 0,31,62 arrive together: R3, R4, R6, R10.
    tag = "R3 R6";
    ref_en = 1'b1;
    ref_sel = '0;
    ref_sel[0] = 1'b1; ref_sel[31] = 1'b1; ref_sel[62] = 1'b1;
    ref_sel[10] = 1'b1; ref_sel[40] = 1'b1;
    ref_recip = 16'd13107;
    shift_amt = 4'd2;
    bin_len = 16'd3;
    bin_recip = 16'd21845;
    for (int s = 0; s < 6; s++) begin
      for (int c = 0; c < NCH; c++)
        samp[c] = (c % 7 == 0) ? 50 + s : 1000 + c * 13 + s * 7;
      do_step(1'b0, 1'b1, (s == 0) ? "R10 three-lane reference sum" : "R4 common average");
    end
    drain();

    // Sparse enables, lane 2 keeps offering data past its quota: R2, R9.
    tag = "R2 R9";
    ref_en = 1'b0;
    shift_amt = 4'd0;
    chan_en = '0;
    for (int c = 0; c < CPL; c++) chan_en[c] = 1'b1;
    for (int c = 62; c < 66; c++) chan_en[c] = 1'b1;
    bin_len = 16'd2;
    bin_recip = 16'd32768;
    for (int s = 0; s < 4; s++) begin
      for (int c = 0; c < NCH; c++) samp[c] = 300 + c * 5 + s * 11;
      do_step(1'b1, (s == 0), "R5 car after referencing off");
    end
    drain();

    // Saturation of one channel's sum: R8.
    tag = "R8";
    chan_en = '0;
    chan_en[5] = 1'b1;
    bin_len = 16'd300;
    bin_recip = 16'd1;
    for (int c = 0; c < NCH; c++) samp[c] = 65535;
    for (int s = 0; s < 300; s++) do_step(1'b0, 1'b0, "R8");
    repeat (300) @(negedge clk);
    chk("R7 all bins reported", expq.size(), 0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule